// File: doc/BRIEF.md
# Three-Byte Hamming ECC Corrector

This block checks a sector of flash data after it has been read. It takes two 24-bit Hamming codes for the same sector. One is the code that was stored next to the data. The other was computed over the data as it came back. The block XORs the two codes into a syndrome. From the syndrome it decides whether the data is clean, whether one data bit flipped, whether the stored code itself took the hit, or whether the damage cannot be repaired. For a single flipped data bit it gives the byte and bit position of that bit inside the sector.

An optional repair path drives a simple synchronous port on an external sector RAM. The path reads the faulty byte, inverts the bad bit and writes the byte back. Only then does the block raise its done pulse, so the sector in the RAM is already correct when the caller sees the result. A blank-page option makes an erased page count as clean. An erased page holds an all-ones stored code and would otherwise report garbage. Generating the code from the data is left to a separate block.

Top module: `ecc3_corrector`

## Requirements
- R1: Byte n of each code occupies bits 8n+7:8n, and the syndrome bytes d0, d1, d2 are the bytewise XOR of the two codes. An all-zero syndrome gives status 0 (clean), with the byte and bit index outputs both 0.
- R2: When `ignore_blank_i` is 1 and the stored code is 0xFFFFFF, the status is 0 whatever the calculated code. When `ignore_blank_i` is 0, the same codes are classified by R3, R6 and R7.
- R3: When every two-bit pair (bits 1:0, 3:2, 5:4, 7:6) of d0, d1 and d2 has exactly one bit set, the status is 1 (data bit corrected).
- R4: For status 1, byte index bit 8 is d2 bit 1. Index bits 7..4 are d1 bits 7, 5, 3, 1 and index bits 3..0 are d0 bits 7, 5, 3, 1. For any other status both index outputs are 0.
- R5: For status 1, bit index bits 2, 1, 0 are d2 bits 7, 5, 3.
- R6: A syndrome with exactly one of its 24 bits set gives status 2 (error in stored code), and the sector RAM is not touched.
- R7: Every other syndrome gives status 3 (uncorrectable).
- R8: Without a repair, `done_o` is high for exactly one cycle, in the cycle after the cycle that samples `start_i`. Status and indices keep their values until the next accepted start.
- R9: With `fix_en_i` set and status 1, the block issues one read of the faulty byte, then in the next cycle writes the returned data XOR a one-hot mask at the bit index to the same address. `done_o` follows in the cycle after the write. Read data is expected one cycle after the read request.
- R10: With `fix_en_i` clear, or with a status other than 1, `ram_req_o` stays low.
- R11: A start that arrives while a repair is in progress is ignored and leaves status, indices and the pending done unchanged.
- R12: After reset, `done_o`, `ram_req_o`, the status and both indices are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Starts a comparison of the two codes |
| stored_code_i | input | 24 | Code read back from flash |
| calc_code_i | input | 24 | Code computed over the read data |
| ignore_blank_i | input | 1 | Treat an all-ones stored code as a clean page |
| fix_en_i | input | 1 | Repair a correctable bit in the sector RAM |
| done_o | output | 1 | One-cycle result-valid pulse |
| status_o | output | 2 | 0 clean, 1 corrected, 2 code error, 3 uncorrectable |
| byte_idx_o | output | 9 | Byte position of the flipped data bit |
| bit_idx_o | output | 3 | Bit position inside that byte |
| ram_req_o | output | 1 | Sector RAM access request |
| ram_we_o | output | 1 | Write when high, read when low |
| ram_addr_o | output | 9 | Sector RAM byte address |
| ram_wdata_o | output | 8 | Corrected byte to write |
| ram_rdata_i | input | 8 | Read data, valid one cycle after a read request |

## Verification
The hardest situation to reach from the ports is a second start that arrives during the read-then-write repair. Only a narrow two-cycle window allows it, and the classifier must drop that start while the pending done still arrives on time. The bench starts a repair and then drives a clean-code start in the very next cycle, which is the read cycle. It then checks the exact cycles in which done rises and falls, and confirms that the status still reports the correction. Syndromes for correctable cases are built in the bench from a chosen byte and bit position. This covers the extreme indices 0 and 511/7 as well as middle values.

// File: rtl/ecc3_pkg.sv
package ecc3_pkg;
  localparam int BYTE_W     = 8;
  localparam int CODE_BYTES = 3;
  localparam int CODE_W     = BYTE_W * CODE_BYTES;
  localparam int PAIRS      = CODE_W / 2;

  typedef enum logic [1:0] {
    ECC_CLEAN    = 2'd0,
    ECC_FIXED    = 2'd1,
    ECC_CODE_ERR = 2'd2,
    ECC_UNCORR   = 2'd3
  } ecc_status_e;

  typedef enum logic [1:0] {
    RMW_IDLE = 2'd0,
    RMW_RD   = 2'd1,
    RMW_WR   = 2'd2
  } rmw_state_e;
endpackage

// File: rtl/ecc3_syndrome.sv
module ecc3_syndrome
  import ecc3_pkg::*;
(
  input  logic [CODE_W-1:0] stored_i,
  input  logic [CODE_W-1:0] calc_i,
  input  logic              ignore_blank_i,
  output logic [CODE_W-1:0] syn_o,
  output logic              zero_o,
  output logic              blank_o,
  output logic              pairs_ok_o,
  output logic              single_o
);
  logic [PAIRS-1:0] pair_one;

  assign syn_o = stored_i ^ calc_i;

  // each complementary pair must hold exactly one set bit
  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    assign pair_one[p] = syn_o[2*p] ^ syn_o[2*p+1];
  end

  assign zero_o     = (syn_o == '0);
  assign blank_o    = ignore_blank_i && (stored_i == {CODE_W{1'b1}});
  assign pairs_ok_o = &pair_one;
  assign single_o   = !zero_o && ((syn_o & (syn_o - 1'b1)) == '0);
endmodule

// File: rtl/ecc3_locate.sv
module ecc3_locate
  import ecc3_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int BIT_W  = 3
) (
  input  logic [CODE_W-1:0] syn_i,
  output logic [ADDR_W-1:0] byte_idx_o,
  output logic [BIT_W-1:0]  bit_idx_o
);
  localparam int NIB = BYTE_W / 2;

  // odd bits of the low two syndrome bytes carry the low byte index
  for (genvar k = 0; k < NIB; k++) begin : g_low
    assign byte_idx_o[k]       = syn_i[2*k+1];
    assign byte_idx_o[NIB + k] = syn_i[BYTE_W + 2*k+1];
  end
  assign byte_idx_o[ADDR_W-1] = syn_i[2*BYTE_W + 1];

  // upper odd bits of the top syndrome byte carry the bit index
  for (genvar j = 0; j < BIT_W; j++) begin : g_bit
    assign bit_idx_o[j] = syn_i[2*BYTE_W + 2*j + 3];
  end
endmodule

// File: rtl/ecc3_rmw.sv
module ecc3_rmw
  import ecc3_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int BIT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BIT_W-1:0]  bit_i,
  output logic              busy_o,
  output logic              wr_phase_o,
  output logic              ram_req_o,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [BYTE_W-1:0] ram_wdata_o,
  input  logic [BYTE_W-1:0] ram_rdata_i
);
  rmw_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-1:0] mask_q;
  logic              load_en;

  assign load_en = (state_q == RMW_IDLE) && go_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      RMW_IDLE: if (go_i) state_d = RMW_RD;
      RMW_RD:   state_d = RMW_WR;
      RMW_WR:   state_d = RMW_IDLE;
      default:  state_d = RMW_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RMW_IDLE;
      addr_q  <= '0;
      mask_q  <= '0;
    end else begin
      state_q <= state_d;
      if (load_en) begin
        addr_q <= addr_i;
        mask_q <= BYTE_W'(1) << bit_i;
      end
    end
  end

  assign busy_o      = (state_q != RMW_IDLE);
  assign wr_phase_o  = (state_q == RMW_WR);
  assign ram_req_o   = busy_o;
  assign ram_we_o    = wr_phase_o;
  assign ram_addr_o  = addr_q;
  assign ram_wdata_o = ram_rdata_i ^ mask_q;
endmodule

// File: rtl/ecc3_corrector.sv
module ecc3_corrector
  import ecc3_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int BIT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [23:0]       stored_code_i,
  input  logic [23:0]       calc_code_i,
  input  logic              ignore_blank_i,
  input  logic              fix_en_i,
  output logic              done_o,
  output logic [1:0]        status_o,
  output logic [ADDR_W-1:0] byte_idx_o,
  output logic [BIT_W-1:0]  bit_idx_o,
  output logic              ram_req_o,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [7:0]        ram_wdata_o,
  input  logic [7:0]        ram_rdata_i
);
  logic [1:0]        rst_sync_q;
  logic              rst_core_n;
  logic [CODE_W-1:0] syn;
  logic              syn_zero, syn_blank, syn_pairs, syn_single;
  logic [ADDR_W-1:0] loc_byte;
  logic [BIT_W-1:0]  loc_bit;
  logic              rmw_busy, rmw_wr, start_ok, go_fix;
  ecc_status_e       status_q, status_d;
  logic [ADDR_W-1:0] byte_q, byte_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic              done_q, done_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  ecc3_syndrome u_syn (
    .stored_i       (stored_code_i),
    .calc_i         (calc_code_i),
    .ignore_blank_i (ignore_blank_i),
    .syn_o          (syn),
    .zero_o         (syn_zero),
    .blank_o        (syn_blank),
    .pairs_ok_o     (syn_pairs),
    .single_o       (syn_single)
  );

  ecc3_locate #(.ADDR_W(ADDR_W), .BIT_W(BIT_W)) u_loc (
    .syn_i      (syn),
    .byte_idx_o (loc_byte),
    .bit_idx_o  (loc_bit)
  );

  assign start_ok = start_i && !rmw_busy;

  always_comb begin
    status_d = status_q;
    byte_d   = byte_q;
    bit_d    = bit_q;
    go_fix   = 1'b0;
    done_d   = rmw_wr;
    if (start_ok) begin
      done_d = 1'b1;
      byte_d = '0;
      bit_d  = '0;
      if (syn_zero || syn_blank) begin
        status_d = ECC_CLEAN;
      end else if (syn_pairs) begin
        status_d = ECC_FIXED;
        byte_d   = loc_byte;
        bit_d    = loc_bit;
        if (fix_en_i) begin
          go_fix = 1'b1;
          done_d = 1'b0;
        end
      end else if (syn_single) begin
        status_d = ECC_CODE_ERR;
      end else begin
        status_d = ECC_UNCORR;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      status_q <= ECC_CLEAN;
      byte_q   <= '0;
      bit_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= done_d;
      if (start_ok) begin
        status_q <= status_d;
        byte_q   <= byte_d;
        bit_q    <= bit_d;
      end
    end
  end

  ecc3_rmw #(.ADDR_W(ADDR_W), .BIT_W(BIT_W)) u_rmw (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .go_i        (go_fix),
    .addr_i      (loc_byte),
    .bit_i       (loc_bit),
    .busy_o      (rmw_busy),
    .wr_phase_o  (rmw_wr),
    .ram_req_o   (ram_req_o),
    .ram_we_o    (ram_we_o),
    .ram_addr_o  (ram_addr_o),
    .ram_wdata_o (ram_wdata_o),
    .ram_rdata_i (ram_rdata_i)
  );

  assign done_o     = done_q;
  assign status_o   = status_q;
  assign byte_idx_o = byte_q;
  assign bit_idx_o  = bit_q;
endmodule

// File: rtl/ecc3_corrector_chk.sv
module ecc3_corrector_chk #(
  parameter int ADDR_W = 9,
  parameter int BIT_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              done_o,
  input logic [1:0]        status_o,
  input logic [ADDR_W-1:0] byte_idx_o,
  input logic [BIT_W-1:0]  bit_idx_o,
  input logic              ram_req_o,
  input logic              ram_we_o
);
  assert_write_after_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we_o |-> $past(ram_req_o && !ram_we_o));

  assert_write_then_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we_o |=> done_o);

  assert_ram_only_when_fixed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ram_req_o |-> (status_o == 2'd1));

  assert_loc_zero_unless_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o != 2'd1) |-> (byte_idx_o == '0 && bit_idx_o == '0));

  assert_done_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(start_i) || $past(ram_we_o)));
endmodule

bind ecc3_corrector ecc3_corrector_chk #(.ADDR_W(ADDR_W), .BIT_W(BIT_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .done_o     (done_o),
  .status_o   (status_o),
  .byte_idx_o (byte_idx_o),
  .bit_idx_o  (bit_idx_o),
  .ram_req_o  (ram_req_o),
  .ram_we_o   (ram_we_o)
);

// File: tb/ecc3_corrector_tb.sv
`timescale 1ns/1ps
module ecc3_corrector_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [23:0] stored_code_i = '0;
  logic [23:0] calc_code_i = '0;
  logic        ignore_blank_i = 1'b0;
  logic        fix_en_i = 1'b0;
  logic        done_o;
  logic [1:0]  status_o;
  logic [8:0]  byte_idx_o;
  logic [2:0]  bit_idx_o;
  logic        ram_req_o, ram_we_o;
  logic [8:0]  ram_addr_o;
  logic [7:0]  ram_wdata_o;
  logic [7:0]  rd_q = '0;

  logic [7:0]  mem [512];
  int          n_chk = 0, n_fail = 0;
  int          req_cnt = 0, wr_cnt = 0;
  bit          finished = 0;

  always #2 clk = ~clk;

  ecc3_corrector dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .stored_code_i(stored_code_i), .calc_code_i(calc_code_i),
    .ignore_blank_i(ignore_blank_i), .fix_en_i(fix_en_i),
    .done_o(done_o), .status_o(status_o),
    .byte_idx_o(byte_idx_o), .bit_idx_o(bit_idx_o),
    .ram_req_o(ram_req_o), .ram_we_o(ram_we_o),
    .ram_addr_o(ram_addr_o), .ram_wdata_o(ram_wdata_o),
    .ram_rdata_i(rd_q)
  );

  always @(posedge clk) begin
    if (ram_req_o) begin
      req_cnt <= req_cnt + 1;
      if (ram_we_o) begin
        mem[ram_addr_o] <= ram_wdata_o;
        wr_cnt <= wr_cnt + 1;
      end else begin
        rd_q <= mem[ram_addr_o];
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] mk_syn(input logic [8:0] b, input logic [2:0] t);
    logic [23:0] s;
    s = '0;
    for (int k = 0; k < 4; k++) begin
      s[2*k+1] = b[k];     s[2*k]   = ~b[k];
      s[8+2*k+1] = b[4+k]; s[8+2*k] = ~b[4+k];
    end
    s[17] = b[8]; s[16] = ~b[8];
    s[19] = t[0]; s[18] = ~t[0];
    s[21] = t[1]; s[20] = ~t[1];
    s[23] = t[2]; s[22] = ~t[2];
    return s;
  endfunction

  // drive one start and return cycles until done
  task automatic run(input logic [23:0] st, input logic [23:0] ca, input logic ign,
                     input logic fx, output int lat);
    @(negedge clk);
    stored_code_i = st; calc_code_i = ca; ignore_blank_i = ign; fix_en_i = fx;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    lat = 1;
    while (!done_o && lat < 20) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic t_reset();
    chk("R12 done", done_o, 0);
    chk("R12 status", status_o, 0);
    chk("R12 byte", byte_idx_o, 0);
    chk("R12 bit", bit_idx_o, 0);
    chk("R12 req", ram_req_o, 0);
  endtask

  task automatic t_clean(input logic [23:0] c);
    int lat;
    run(c, c, 1'b0, 1'b1, lat);
    chk("R1 status", status_o, 0);
    chk("R1 byte", byte_idx_o, 0);
    chk("R8 latency", lat, 1);
    @(negedge clk);
    chk("R8 pulse width", done_o, 0);
    chk("R8 hold", status_o, 0);
  endtask

  task automatic t_correct(input logic [8:0] b, input logic [2:0] t, input logic [23:0] c);
    int lat, r0;
    r0 = req_cnt;
    run(c ^ mk_syn(b, t), c, 1'b0, 1'b0, lat);
    chk("R3 status", status_o, 1);
    chk("R4 byte", byte_idx_o, b);
    chk("R5 bit", bit_idx_o, t);
    chk("R8 latency", lat, 1);
    chk("R10 no ram", req_cnt - r0, 0);
  endtask

  task automatic t_code_err(input int pos);
    int lat, r0;
    r0 = req_cnt;
    run(24'h5A5A5A ^ (24'h1 << pos), 24'h5A5A5A, 1'b0, 1'b1, lat);
    chk("R6 status", status_o, 2);
    chk("R6 byte", byte_idx_o, 0);
    chk("R6 no ram", req_cnt - r0, 0);
  endtask

  task automatic t_uncorr(input logic [23:0] s);
    int lat, r0;
    r0 = req_cnt;
    run(24'h00C3A1 ^ s, 24'h00C3A1, 1'b0, 1'b1, lat);
    chk("R7 status", status_o, 3);
    chk("R7 no ram", req_cnt - r0, 0);
  endtask

  task automatic t_blank();
    int lat;
    run(24'hFFFFFF, 24'h123456, 1'b1, 1'b1, lat);
    chk("R2 ignore set", status_o, 0);
    run(24'hFFFFFF, 24'h000000, 1'b0, 1'b0, lat);
    chk("R2 ignore clear", status_o, 3);
    run(24'hFFFFFF ^ mk_syn(9'd77, 3'd2), 24'hFFFFFF, 1'b1, 1'b0, lat);
    chk("R2 not blank", status_o, 1);
  endtask

  task automatic t_fix(input logic [8:0] b, input logic [2:0] t);
    int lat, w0, r0;
    logic [7:0] orig, nb;
    logic [8:0] other;
    other = b ^ 9'd1;
    orig = mem[b]; nb = mem[other];
    w0 = wr_cnt; r0 = req_cnt;
    run(24'h3C3C3C ^ mk_syn(b, t), 24'h3C3C3C, 1'b0, 1'b1, lat);
    chk("R9 latency", lat, 3);
    chk("R9 status", status_o, 1);
    chk("R9 byte flipped", mem[b], orig ^ (8'h1 << t));
    chk("R9 neighbour", mem[other], nb);
    chk("R9 one write", wr_cnt - w0, 1);
    chk("R9 two accesses", req_cnt - r0, 2);
  endtask

  task automatic t_busy();
    @(negedge clk);
    stored_code_i = 24'h0F0F0F ^ mk_syn(9'd300, 3'd5); calc_code_i = 24'h0F0F0F;
    ignore_blank_i = 1'b0; fix_en_i = 1'b1; start_i = 1'b1;
    @(negedge clk);
    stored_code_i = 24'h111111; calc_code_i = 24'h111111;
    @(negedge clk);
    start_i = 1'b0;
    chk("R11 no early done", done_o, 0);
    @(negedge clk);
    chk("R11 done on time", done_o, 1);
    chk("R11 status kept", status_o, 1);
    chk("R11 byte kept", byte_idx_o, 300);
    @(negedge clk);
    chk("R11 single done", done_o, 0);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 8'((i * 7 + 3) & 255);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_clean(24'h123456);
    t_clean(24'hFFFFFF);
    t_correct(9'd0, 3'd0, 24'hA5A5A5);
    t_correct(9'd511, 3'd7, 24'h000000);
    t_correct(9'd170, 3'd3, 24'h6E21F0);
    t_correct(9'd257, 3'd6, 24'hFFFFFF);
    t_code_err(0);
    t_code_err(13);
    t_code_err(23);
    t_uncorr(24'h000003);
    t_uncorr(mk_syn(9'd5, 3'd1) & 24'h00FFFF);
    t_blank();
    t_fix(9'd0, 3'd0);
    t_fix(9'd511, 3'd7);
    t_fix(9'd222, 3'd4);
    t_busy();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule